// File: doc/BRIEF.md
# Memory Window Address Translator

This block decides which of a socket's memory windows a system memory access falls into, and where that access lands on the card. Each window holds a start page, a stop page and an offset page, each 12 bits wide and counted in 4 KB pages. An access page lies inside a window when it is between the start and stop pages, both ends included. Only windows whose enable bit is set take part. When more than one enabled window covers the page, the window with the lowest number is chosen.

For the chosen window, the card address is the access page plus the window's offset page, wrapping within the 12-bit page space, with the low 12 address bits passed through unchanged. The window's spare upper register bits supply a 16-bit data-width select and a two-bit wait-state count, which go out with the hit. The register contents come from an external register file as flat vectors. All outputs are registered, so results appear one clock after the address.

Top module: `mem_window_xlate`

## Requirements
- R1: While reset is held and on the first cycle after it, hit, win_idx, card_addr, wide16 and wait_st are all zero.
- R2: Window i matches when its enable bit is set and start[11:0] <= sys_addr[23:12] <= stop[11:0], both bounds inclusive; its register fields sit at bits i*16 of the flat vectors.
- R3: A window whose bit in win_en is clear never produces a hit, whatever its register contents.
- R4: When several enabled windows match, win_idx reports the lowest-numbered one, and its fields drive the other outputs.
- R5: On a hit, card_addr[23:12] = (sys_addr[23:12] + offset[11:0]) mod 4096 and card_addr[11:0] = sys_addr[11:0].
- R6: On a hit, wide16 equals bit 15 of the chosen window's start register and wait_st equals bits 15:14 of its stop register.
- R7: With no matching window, hit, win_idx, card_addr, wide16 and wait_st are all zero.
- R8: Outputs reflect the inputs present at the previous rising clock edge (one cycle of latency).
- R9: A window whose start page is above its stop page matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_addr | input | 24 | System memory address |
| win_start | input | 80 | Start registers, 16 bits per window; bit 15 is the 16-bit select |
| win_stop | input | 80 | Stop registers, 16 bits per window; bits 15:14 are wait states |
| win_offset | input | 80 | Offset registers, 16 bits per window |
| win_en | input | 5 | Per-window enable |
| hit | output | 1 | Address fell in an enabled window |
| win_idx | output | 3 | Number of the chosen window |
| card_addr | output | 24 | Translated card address |
| wide16 | output | 1 | Data-width select of the chosen window |
| wait_st | output | 2 | Wait-state count of the chosen window |

## Verification
A single enabled window is swept over every one of the 4096 pages, which separates inside from outside at both inclusive bounds and checks the offset sum; the same sweep with the window disabled tells a dropped enable from a correct one. An offset that carries past the top of the page space exposes a translator that fails to wrap, and a window with its bounds reversed or equal shows whether the compare direction and inclusiveness are right. Five distinct adjacent windows plus an overlapping pair swept across all pages tell apart correct lowest-number priority from any other selection order and confirm that width and wait fields follow the chosen window.

// File: rtl/mem_window_xlate.sv
module mem_window_xlate #(
  parameter int NWIN   = 5,
  parameter int PAGE_W = 12,
  parameter int OFS_W  = 12,
  parameter int REG_W  = 16,
  localparam int AW    = PAGE_W + OFS_W,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         sys_addr,
  input  logic [NWIN*REG_W-1:0] win_start,
  input  logic [NWIN*REG_W-1:0] win_stop,
  input  logic [NWIN*REG_W-1:0] win_offset,
  input  logic [NWIN-1:0]       win_en,
  output logic                  hit,
  output logic [IDX_W-1:0]      win_idx,
  output logic [AW-1:0]         card_addr,
  output logic                  wide16,
  output logic [1:0]            wait_st
);

  logic [PAGE_W-1:0] page;
  logic [NWIN-1:0]   match;
  logic [NWIN-1:0]   unused_spare;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [PAGE_W-1:0] card_page;

  assign page = sys_addr[AW-1:OFS_W];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [PAGE_W-1:0] lo, hi;
    assign lo = win_start[i*REG_W +: PAGE_W];
    assign hi = win_stop[i*REG_W +: PAGE_W];
    assign match[i] = win_en[i] && (page >= lo) && (page <= hi);
    assign unused_spare[i] = ^{win_start[i*REG_W+PAGE_W +: REG_W-PAGE_W-1],
                               win_stop[i*REG_W+PAGE_W +: REG_W-PAGE_W-2],
                               win_offset[i*REG_W+PAGE_W +: REG_W-PAGE_W]};
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign card_page = page + win_offset[sel_idx*REG_W +: PAGE_W];

  always_ff @(posedge clk) begin
    if (!rst_n || !sel_hit) begin
      hit       <= 1'b0;
      win_idx   <= '0;
      card_addr <= '0;
      wide16    <= 1'b0;
      wait_st   <= 2'b00;
    end else begin
      hit       <= 1'b1;
      win_idx   <= sel_idx;
      card_addr <= {card_page, sys_addr[OFS_W-1:0]};
      wide16    <= win_start[sel_idx*REG_W + REG_W - 1];
      wait_st   <= win_stop[sel_idx*REG_W + REG_W - 2 +: 2];
    end
  end

  assert_hit_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(win_en) >> win_idx) & NWIN'(1)) != '0));

  assert_none_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_en) == '0) |-> !hit);

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (card_addr[OFS_W-1:0] == $past(sys_addr[OFS_W-1:0])));

  assert_quiet_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (card_addr == '0 && win_idx == '0 && !wide16 && wait_st == 2'b00));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(win_idx) < NWIN));

endmodule

// File: tb/mem_window_xlate_test.sv
module mem_window_xlate_test;
  localparam int NW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] sys_addr = '0;
  logic [NW*16-1:0] win_start, win_stop, win_offset;
  logic [NW-1:0] win_en = '0;
  logic hit, wide16;
  logic [2:0] win_idx;
  logic [23:0] card_addr;
  logic [1:0] wait_st;

  logic [15:0] st [NW];
  logic [15:0] sp [NW];
  logic [15:0] of [NW];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      win_start[i*16 +: 16]  = st[i];
      win_stop[i*16 +: 16]   = sp[i];
      win_offset[i*16 +: 16] = of[i];
    end
  end

  mem_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr),
    .win_start(win_start), .win_stop(win_stop), .win_offset(win_offset),
    .win_en(win_en), .hit(hit), .win_idx(win_idx), .card_addr(card_addr),
    .wide16(wide16), .wait_st(wait_st)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h addr %h", req, act, exp, sys_addr);
    end
  endtask

  task automatic probe(input logic [23:0] a, input string req);
    logic        e_hit = 1'b0;
    logic [2:0]  e_idx = '0;
    logic [23:0] e_card = '0;
    logic        e_wide = 1'b0;
    logic [1:0]  e_wait = '0;
    int pg = int'(a[23:12]);
    for (int i = NW - 1; i >= 0; i--) begin
      if (win_en[i] && pg >= int'(st[i][11:0]) && pg <= int'(sp[i][11:0])) begin
        e_hit  = 1'b1;
        e_idx  = 3'(i);
        e_card = {12'((pg + int'(of[i][11:0])) % 4096), a[11:0]};
        e_wide = st[i][15];
        e_wait = sp[i][15:14];
      end
    end
    @(negedge clk);
    sys_addr = a;
    @(negedge clk);
    chk({req, " hit"}, 32'(hit), 32'(e_hit));
    chk({req, " idx"}, 32'(win_idx), 32'(e_idx));
    chk({req, " card"}, 32'(card_addr), 32'(e_card));
    chk({req, " wide/wait"}, {29'd0, wide16, wait_st}, {29'd0, e_wide, e_wait});
  endtask

  task automatic clear_windows();
    for (int i = 0; i < NW; i++) begin
      st[i] = 16'h0000; sp[i] = 16'h0000; of[i] = 16'h0000;
    end
    win_en = '0;
  endtask

  initial begin
    clear_windows();
    st[0] = 16'h8000; sp[0] = 16'hCFFF; win_en = 5'b00001;
    sys_addr = 24'h123456;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset even with a matching window
    chk("R1 reset", {24'd0, 1'b0, hit, win_idx, wide16, wait_st}, 32'd0);
    chk("R1 reset card", 32'(card_addr), 32'd0);
    rst_n = 1'b1;
    clear_windows();

    // R2 R5 R6 R7 R8: single window sweep over every page
    st[2] = 16'h8100; sp[2] = 16'h81FF; of[2] = 16'hF050; win_en = 5'b00100;
    for (int p = 0; p < 4096; p++) probe({12'(p), 12'(p * 7)}, "R2/R5/R6/R7/R8 single");

    // R3: same window disabled, swept through its range
    win_en = 5'b00000;
    for (int p = 'h0F0; p < 'h210; p++) probe({12'(p), 12'hABC}, "R3 disabled");
    // R3: other windows enabled but not this one
    sp[0] = 16'h0000; st[0] = 16'h0FFF; win_en = 5'b11011;
    for (int p = 'h100; p < 'h200; p += 17) probe({12'(p), 12'h001}, "R3 masked");

    // R5: offset carry wraps past the top page
    clear_windows();
    st[1] = 16'h0200; sp[1] = 16'h4FFF; of[1] = 16'h0F00; win_en = 5'b00010;
    probe(24'h200123, "R5 wrap");
    probe(24'hFFFFFF, "R5 wrap top");
    probe(24'h0FF000, "R5 no wrap");

    // R9 and inclusive single-page window
    clear_windows();
    st[3] = 16'h0300; sp[3] = 16'h02FF; win_en = 5'b01000;
    for (int p = 'h2F0; p < 'h310; p++) probe({12'(p), 12'h777}, "R9 reversed");
    st[4] = 16'h0ABC; sp[4] = 16'h4ABC; of[4] = 16'h0001; win_en = 5'b10000;
    for (int p = 'hAB8; p < 'hAC0; p++) probe({12'(p), 12'hFFF}, "R2 single page");

    // R4: five adjacent windows plus overlap, priority sweep
    clear_windows();
    for (int i = 0; i < NW; i++) begin
      st[i] = 16'((i * 'h300) | ((i & 1) << 15));
      sp[i] = 16'((i * 'h300 + 'h3FF) | (i << 14));
      of[i] = 16'(i * 'h111);
    end
    win_en = 5'b11111;
    for (int p = 0; p < 4096; p += 3) probe({12'(p), 12'(p)}, "R4/R6 priority");
    win_en = 5'b11010;
    for (int p = 0; p < 4096; p += 5) probe({12'(p), 12'h5A5}, "R4 partial enable");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule